// File: doc/BRIEF.md
# Flexible Second-Operand Shifter

This unit forms the second operand that an ALU consumes, together with the carry that a logical operation would write back as its carry flag. It is purely combinational. A source select picks one of three forms: a constant built from an 8-bit byte rotated right by an even amount, a register value shifted by a 5-bit amount carried in the instruction, or a register value shifted by an amount read from the low byte of a second register.

The instruction-amount form does not behave like a plain barrel shifter. Each shift type has its own legal range, and the zero field value has its own meaning for each type. The register-amount form accepts any amount from 0 to 255. Amounts of 32 and above saturate, or wrap for rotation. The carry-out is always the last bit that leaves the operand. It falls back to the incoming carry flag when no bit leaves the operand.

Top module: `operand2_shifter`

## Requirements
- R1: With `src_sel` = 00 the operand is `imm_byte` zero-extended to 32 bits and rotated right by 2×`imm_rot` positions.
- R2: With `src_sel` = 00 the carry-out equals `carry_in` when `imm_rot` is 0, and equals bit 31 of the operand otherwise.
- R3: With `src_sel` = 01 and `shift_kind` = 00 (shift left), `imm_amt` values 1 to 31 shift left by that amount. The value 0 passes the operand and `carry_in` through unchanged.
- R4: With `src_sel` = 01 and `shift_kind` = 01 (logical right) or 10 (arithmetic right), `imm_amt` values 1 to 31 shift by that amount. The value 0 means a shift of 32.
- R5: With `src_sel` = 01 and `shift_kind` = 11 (rotate right), `imm_amt` values 1 to 31 rotate by that amount. The value 0 selects rotate-with-carry: the result is {`carry_in`, op[31:1]} and the carry-out is op[0].
- R6: With `src_sel` = 10 only `amt_value[7:0]` is used as the amount. An amount of 0 passes the operand and `carry_in` through unchanged.
- R7: With `src_sel` = 10 and an amount of 32 or more, shift left gives 0 with carry op[0] at exactly 32 and carry 0 above 32. Logical right gives 0 with carry op[31] at exactly 32 and carry 0 above 32. Arithmetic right gives 32 copies of op[31], with carry op[31].
- R8: With `src_sel` = 10 and rotate right, a nonzero amount rotates by the amount modulo 32, and the carry-out is bit 31 of the result. A nonzero multiple of 32 leaves the operand unchanged, with carry op[31].
- R9: For every shift by 1 to 31 positions the carry-out is the last bit shifted out: op[32−n] for a left shift and op[n−1] for a right shift or rotation.
- R10: With `src_sel` = 11 the operand is `op_value` unchanged and the carry-out equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_value | input | 32 | Register value to be shifted |
| amt_value | input | 32 | Register holding the shift amount in its low byte |
| carry_in | input | 1 | Current carry flag |
| shift_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| src_sel | input | 2 | 00 rotated byte, 01 shift by field, 10 shift by register, 11 pass |
| imm_byte | input | 8 | Byte for the rotated constant |
| imm_rot | input | 4 | Half of the constant's rotation amount |
| imm_amt | input | 5 | Shift amount field from the instruction |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Immediate assertions beside the logic check several properties whenever the inputs change. The rotated constant keeps the popcount of its byte, and an unrotated constant keeps the incoming carry. A zero register amount and the pass select leave operand and carry untouched. Rotations keep the popcount, rotate-with-carry puts the carry flag in bit 31, and large logical shifts give zero. Only the bench's scenarios can show that each amount lands on the exact bit positions and carry bit. Its reference model steps one bit at a time across every type, amounts 0 to 40, the extremes of the low byte, and the zero-field encodings.

// File: rtl/operand2_shifter.sv
module operand2_shifter (
  input  logic [31:0] op_value,
  input  logic [31:0] amt_value,
  input  logic        carry_in,
  input  logic [1:0]  shift_kind,
  input  logic [1:0]  src_sel,
  input  logic [7:0]  imm_byte,
  input  logic [3:0]  imm_rot,
  input  logic [4:0]  imm_amt,
  output logic [31:0] operand,
  output logic        carry_out
);

  localparam logic [1:0] K_LSL = 2'b00;
  localparam logic [1:0] K_LSR = 2'b01;
  localparam logic [1:0] K_ASR = 2'b10;
  localparam logic [1:0] K_ROR = 2'b11;
  localparam logic [1:0] S_IMM = 2'b00;
  localparam logic [1:0] S_FLD = 2'b01;
  localparam logic [1:0] S_REG = 2'b10;

  logic [7:0]  eff_amt;
  logic        do_pass, do_rrx;
  logic [63:0] lsl_w, lsr_w, asr_w;
  logic [5:0]  asr_a;
  logic [4:0]  ror_r, crot;
  logic [31:0] ror_v, const_v, cbyte;

  always_comb begin
    eff_amt = 8'd0;
    do_pass = 1'b0;
    do_rrx  = 1'b0;
    case (src_sel)
      S_FLD: begin
        eff_amt = {3'b000, imm_amt};
        if (imm_amt == 5'd0) begin
          if (shift_kind == K_LSL) do_pass = 1'b1;
          else if (shift_kind == K_ROR) do_rrx = 1'b1;
          else eff_amt = 8'd32;
        end
      end
      S_REG: begin
        eff_amt = amt_value[7:0];
        do_pass = (amt_value[7:0] == 8'd0);
      end
      default: do_pass = (src_sel != S_IMM);
    endcase
  end

  assign lsl_w = {32'd0, op_value} << eff_amt;
  assign lsr_w = {op_value, 32'd0} >> eff_amt;
  assign asr_a = (eff_amt >= 8'd32) ? 6'd32 : eff_amt[5:0];
  assign asr_w = $signed({op_value, 32'd0}) >>> asr_a;
  assign ror_r = eff_amt[4:0];
  assign ror_v = (op_value >> ror_r) | (op_value << (6'd32 - {1'b0, ror_r}));

  assign cbyte   = {24'd0, imm_byte};
  assign crot    = {imm_rot, 1'b0};
  assign const_v = (cbyte >> crot) | (cbyte << (6'd32 - {1'b0, crot}));

  always_comb begin
    operand   = op_value;
    carry_out = carry_in;
    if (src_sel == S_IMM) begin
      operand   = const_v;
      carry_out = (imm_rot == 4'd0) ? carry_in : const_v[31];
    end else if (do_rrx) begin
      operand   = {carry_in, op_value[31:1]};
      carry_out = op_value[0];
    end else if (!do_pass) begin
      case (shift_kind)
        K_LSL: begin operand = lsl_w[31:0];  carry_out = lsl_w[32]; end
        K_LSR: begin operand = lsr_w[63:32]; carry_out = lsr_w[31]; end
        K_ASR: begin operand = asr_w[63:32]; carry_out = asr_w[31]; end
        default: begin operand = ror_v;      carry_out = ror_v[31]; end
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{amt_value[31:8], lsl_w[63:33], lsr_w[30:0], asr_w[30:0]};

  always_comb begin
    if (src_sel == S_IMM)
      p_const_bits_r1: assert ($countones(operand) == $countones(imm_byte));
    if (src_sel == S_IMM && imm_rot == 4'd0)
      p_const_carry_r2: assert (carry_out == carry_in);
    if (src_sel == S_FLD && shift_kind == K_LSL && imm_amt == 5'd0)
      p_lsl_zero_field_r3: assert (operand == op_value && carry_out == carry_in);
    if (src_sel == S_FLD && shift_kind == K_LSR && imm_amt == 5'd0)
      p_lsr_field32_r4: assert (operand == 32'd0 && carry_out == op_value[31]);
    if (src_sel == S_FLD && shift_kind == K_ROR && imm_amt == 5'd0)
      p_rrx_r5: assert (operand[31] == carry_in && carry_out == op_value[0]);
    if (src_sel == S_REG && amt_value[7:0] == 8'd0)
      p_reg_zero_r6: assert (operand == op_value && carry_out == carry_in);
    if (src_sel == S_REG && (shift_kind == K_LSL || shift_kind == K_LSR) && amt_value[7:0] > 8'd32)
      p_big_logical_r7: assert (operand == 32'd0 && !carry_out);
    if (src_sel != S_IMM && shift_kind == K_ROR && !(src_sel == S_FLD && imm_amt == 5'd0))
      p_ror_bits_r8: assert ($countones(operand) == $countones(op_value));
    if (src_sel == 2'b11)
      p_pass_r10: assert (operand == op_value && carry_out == carry_in);
  end

endmodule

// File: tb/operand2_shifter_test.sv
module operand2_shifter_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] op_value, amt_value, operand;
  logic        carry_in, carry_out;
  logic [1:0]  shift_kind, src_sel;
  logic [7:0]  imm_byte;
  logic [3:0]  imm_rot;
  logic [4:0]  imm_amt;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  operand2_shifter uut (
    .op_value(op_value), .amt_value(amt_value), .carry_in(carry_in),
    .shift_kind(shift_kind), .src_sel(src_sel), .imm_byte(imm_byte),
    .imm_rot(imm_rot), .imm_amt(imm_amt), .operand(operand), .carry_out(carry_out)
  );

  logic [31:0] pats [4];
  initial begin
    pats[0] = 32'h8000_0001; pats[1] = 32'hF0E1_D2C3;
    pats[2] = 32'h7FFF_FFFE; pats[3] = 32'h5A3C_96E1;
  end

  // Bit-serial model: one position per step, carry = bit that leaves.
  task automatic model(input logic [31:0] x, input int kind, input int amt,
                       input logic cin, output logic [31:0] r, output logic c);
    r = x; c = cin;
    for (int i = 0; i < amt; i++) begin
      case (kind)
        0: begin c = r[31]; r = {r[30:0], 1'b0}; end
        1: begin c = r[0];  r = {1'b0, r[31:1]}; end
        2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
  endtask

  task automatic compare(input string req, input logic [31:0] eo, input logic ec);
    @(negedge clk);
    n_checks++;
    if (operand !== eo || carry_out !== ec) begin
      n_fails++;
      $display("FAIL %s: kind=%0d src=%0d op=%h amt=%h field=%0d -> got %h/%b expected %h/%b",
               req, shift_kind, src_sel, op_value, amt_value, imm_amt, operand, carry_out, eo, ec);
    end
  endtask

  task automatic t_idle;
    @(posedge clk);
    op_value = 0; amt_value = 0; carry_in = 0; shift_kind = 0; src_sel = 0;
    imm_byte = 0; imm_rot = 0; imm_amt = 0;
    compare("R1 idle", 32'd0, 1'b0);
  endtask

  task automatic t_const;
    logic [31:0] r; logic c;
    for (int b = 0; b < 3; b++)
      for (int rot = 0; rot < 16; rot++)
        for (int ci = 0; ci < 2; ci++) begin
          @(posedge clk);
          src_sel = 2'b00; imm_byte = (b == 0) ? 8'h81 : (b == 1) ? 8'hFF : 8'h4E;
          imm_rot = rot[3:0]; carry_in = ci[0]; op_value = pats[b];
          model({24'd0, imm_byte}, 3, 2 * rot, 1'b0, r, c);
          compare(rot == 0 ? "R1/R2 unrotated" : "R1/R2 rotated", r, rot == 0 ? ci[0] : r[31]);
        end
  endtask

  task automatic t_field;
    logic [31:0] r; logic c;
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 4; p++)
          for (int ci = 0; ci < 2; ci++) begin
            @(posedge clk);
            src_sel = 2'b01; shift_kind = k[1:0]; imm_amt = a[4:0];
            op_value = pats[p]; carry_in = ci[0]; amt_value = 32'hFFFF_FFFF;
            if (a == 0 && k == 3) begin
              r = {ci[0], pats[p][31:1]}; c = pats[p][0];
              compare("R5 rotate-with-carry", r, c);
            end else begin
              model(pats[p], k, (a == 0 && k != 0) ? 32 : a, ci[0], r, c);
              compare(k == 0 ? "R3 field" : (k == 3 ? "R5 field" : "R4 field"), r, c);
            end
          end
  endtask

  task automatic t_register;
    logic [31:0] r; logic c; int eff;
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 44; a++)
        for (int p = 0; p < 4; p++)
          for (int ci = 0; ci < 2; ci++) begin
            @(posedge clk);
            eff = (a <= 40) ? a : (a == 41) ? 64 : (a == 42) ? 255 : 256;
            src_sel = 2'b10; shift_kind = k[1:0];
            amt_value = 32'hA5A5_A500 | (eff & 255) | ((eff & 256) != 0 ? 32'h100 : 0);
            op_value = pats[p]; carry_in = ci[0]; imm_amt = 5'd7;
            model(pats[p], k, (eff & 255), ci[0], r, c);
            if ((eff & 255) == 0) compare("R6 zero low byte", r, c);
            else if ((eff & 255) < 32) compare("R9 last bit out", r, c);
            else compare(k == 3 ? "R8 rotate wrap" : "R7 large amount", r, c);
          end
  endtask

  task automatic t_pass;
    for (int k = 0; k < 4; k++)
      for (int ci = 0; ci < 2; ci++) begin
        @(posedge clk);
        src_sel = 2'b11; shift_kind = k[1:0]; op_value = pats[k]; carry_in = ci[0];
        amt_value = 32'd5; imm_amt = 5'd3; imm_byte = 8'h12; imm_rot = 4'd1;
        compare("R10 pass", pats[k], ci[0]);
      end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_const();
    t_field();
    t_register();
    t_pass();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule